// File: doc/BRIEF.md
# Mode-Locked Driver Control Register File

This block is the register bank for the digital control settings of a laser-driver controller. A host reaches it over a simple synchronous register bus. The bus carries an address, write data, a write strobe, a read strobe and read data. The block keeps a pulse-width field, a de-emphasis field, an equalization field and a 9-bit bias setting. It drives the current value of each one out as a parallel control output to the analog side.

Ordinary control writes are gated. First the host writes the unlock code (0x12) to the mode register. That allows exactly one ordinary write, after which the block locks itself again. A write that arrives while the block is locked is dropped, and a sticky error flag goes high.

The bias setting has two write paths:
- An increment register adds a signed 5-bit delta to the bias, saturating at the ends of its range. It needs no unlock.
- A separate address loads the upper eight bias bits directly, under the unlock rule.

The bus is a plain strobe interface with no back-pressure. Every write completes in the cycle its strobe is sampled, and every read returns data on the following cycle.

Top module: `drvctl_regfile`

## Requirements
- R1: After reset:
  - the pulse-width output is 0, the de-emphasis output is 0b000001, and the equalization output is 00;
  - the bias output is 0;
  - the mode register reads 0x00 and the error flag is low.
- R2: A write to the mode address 0x0E stores its data, which reads back from 0x0E. The block is unlocked exactly when the stored value is 0x12; any other value leaves it locked.
- R3: A write to an ordinary address (0x0C, 0x0F, 0x10, 0x11) takes effect only while unlocked. Each accepted ordinary write sets the mode register back to 0x00, so the next ordinary write needs a fresh unlock.
- R4: An ordinary write while locked changes no register. It sets the error flag, which then stays high until reset.
- R5: A write to the bias increment address 0x0D is accepted whether locked or unlocked, and leaves the mode register unchanged.
- R6: Each write to 0x0D adds bits 4:0, taken as a two's complement value from -16 to +15, to the 9-bit bias. The result clamps at 0 and at 511 instead of wrapping.
- R7: Reading 0x0D returns bias bit 0 in bit 7 and the last written delta in bits 4:0, with bits 6:5 reading 0. Write data bit 7 at 0x0D has no direct effect on the bias.
- R8: Address 0x0C reads bias bits 8:1. An accepted write there loads bias bits 8:1 from the write data and leaves bias bit 0 unchanged.
- R9: Field positions are:
  - pulse width in bits 3:0 of 0x0F;
  - de-emphasis in bits 5:0 of 0x10;
  - equalization in bits 2:1 of 0x11.

  All other bits of these addresses read 0, and the outputs follow the stored fields.
- R10: Read data is registered. It updates on the clock edge that samples the read strobe, and holds its value while no read is strobed. Reads never change the mode state.
- R11: A write to an unmapped address changes no register, does not consume an unlock and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pw_ctrl | output | 4 | Pulse-width control field |
| deemph_ctrl | output | 6 | De-emphasis control field |
| eq_ctrl | output | 2 | Equalization control field |
| bias_ctrl | output | 9 | Bias setting |
| wr_err | output | 1 | Sticky flag for a write rejected while locked |

## Verification
Lock-state corruption is the hardest fault to see. A lock that stays open after an accepted write only shows on the next ordinary write, which then lands when it should not; a read of 0x0E one cycle later also exposes it. A stuck-closed lock shows at once as an unchanged control output and a raised error flag. A wrong saturation or sign in the bias adder appears on the bias output on the edge after the increment write. The tests therefore drive the bias to both limits and read bit 0 back through 0x0D.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_BIAS_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] A_BIAS_INC = 8'h0D;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h0E;
  localparam logic [ADDR_W-1:0] A_PW = 8'h0F;
  localparam logic [ADDR_W-1:0] A_DEEMPH = 8'h10;
  localparam logic [ADDR_W-1:0] A_EQ = 8'h11;

  localparam logic [DATA_W-1:0] UNLOCK_CODE = 8'h12;

  typedef struct packed {
    logic mode;
    logic inc;
    logic bias_hi;
    logic pw;
    logic deemph;
    logic eq;
  } wr_dec_t;
endpackage

// File: rtl/drvctl_unlock.sv
module drvctl_unlock #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CODE = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              ord_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic              ord_accept,
  output logic              err_q
);
  logic unlocked;

  assign unlocked   = (mode_q == CODE);
  assign ord_accept = ord_we && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (mode_we)
        mode_q <= wdata;
      else if (ord_accept)
        mode_q <= '0;
      if (ord_we && !unlocked)
        err_q <= 1'b1;
    end
  end

  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ord_accept |=> (mode_q == '0));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_reject_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_we && !unlocked) |=> err_q);
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_we && !ord_we) |=> $stable(mode_q));
endmodule

// File: rtl/drvctl_bias.sv
module drvctl_bias #(
  parameter int BIAS_W = 9,
  parameter int INC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_we,
  input  logic [INC_W-1:0]  delta,
  input  logic              hi_we,
  input  logic [BIAS_W-2:0] hi_data,
  output logic [BIAS_W-1:0] bias_q,
  output logic [INC_W-1:0]  last_delta_q
);
  localparam int SUM_W = BIAS_W + 2;
  localparam logic [BIAS_W-1:0] BIAS_MAX = '1;

  logic signed [SUM_W-1:0] sum;
  logic [BIAS_W-1:0] sat;

  assign sum = $signed({2'b00, bias_q}) +
               $signed({{(SUM_W-INC_W){delta[INC_W-1]}}, delta});

  always_comb begin
    if (sum < 0)
      sat = '0;
    else if (sum > $signed({2'b00, BIAS_MAX}))
      sat = BIAS_MAX;
    else
      sat = sum[BIAS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bias_q       <= '0;
      last_delta_q <= '0;
    end else if (inc_we) begin
      bias_q       <= sat;
      last_delta_q <= delta;
    end else if (hi_we) begin
      bias_q <= {hi_data, bias_q[0]};
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_we && !hi_we) |=> $stable(bias_q));
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_we && !delta[INC_W-1] && bias_q == BIAS_MAX) |=> (bias_q == BIAS_MAX));
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_we && delta[INC_W-1] && bias_q == '0) |=> (bias_q == '0));
  p_lsb_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !inc_we) |=> (bias_q[0] == $past(bias_q[0])));
endmodule

// File: rtl/drvctl_fields.sv
module drvctl_fields #(
  parameter int DATA_W = 8,
  parameter int PW_W   = 4,
  parameter int DE_W   = 6,
  parameter int EQ_W   = 2,
  parameter int EQ_LSB = 1,
  parameter logic [DE_W-1:0] DE_RST = 6'b000001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_we,
  input  logic              de_we,
  input  logic              eq_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [PW_W-1:0]   pw_q,
  output logic [DE_W-1:0]   de_q,
  output logic [EQ_W-1:0]   eq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_q <= '0;
      de_q <= DE_RST;
      eq_q <= '0;
    end else begin
      if (pw_we) pw_q <= wdata[PW_W-1:0];
      if (de_we) de_q <= wdata[DE_W-1:0];
      if (eq_we) eq_q <= wdata[EQ_LSB +: EQ_W];
    end
  end

  p_pw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_we |=> $stable(pw_q));
  p_de_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !de_we |=> $stable(de_q));
  p_eq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !eq_we |=> $stable(eq_q));
endmodule

// File: rtl/drvctl_regfile.sv
module drvctl_regfile
  import drvctl_pkg::*;
#(
  parameter int BIAS_W = 9,
  parameter int INC_W  = 5,
  parameter int PW_W   = 4,
  parameter int DE_W   = 6,
  parameter int EQ_W   = 2,
  parameter int EQ_LSB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PW_W-1:0]   pw_ctrl,
  output logic [DE_W-1:0]   deemph_ctrl,
  output logic [EQ_W-1:0]   eq_ctrl,
  output logic [BIAS_W-1:0] bias_ctrl,
  output logic              wr_err
);
  localparam int LSB_RD_POS = DATA_W - 1;

  wr_dec_t dec;
  logic ord_we, ord_accept;
  logic [DATA_W-1:0] mode_q, rd_next;
  logic [INC_W-1:0] last_delta;

  always_comb begin
    dec         = '0;
    dec.mode    = bus_wr && (bus_addr == A_MODE);
    dec.inc     = bus_wr && (bus_addr == A_BIAS_INC);
    dec.bias_hi = bus_wr && (bus_addr == A_BIAS_HI);
    dec.pw      = bus_wr && (bus_addr == A_PW);
    dec.deemph  = bus_wr && (bus_addr == A_DEEMPH);
    dec.eq      = bus_wr && (bus_addr == A_EQ);
  end

  assign ord_we = dec.bias_hi || dec.pw || dec.deemph || dec.eq;

  drvctl_unlock #(.DATA_W(DATA_W), .CODE(UNLOCK_CODE)) u_unlock (
    .clk(clk), .rst_n(rst_n), .mode_we(dec.mode), .ord_we(ord_we),
    .wdata(bus_wdata), .mode_q(mode_q), .ord_accept(ord_accept), .err_q(wr_err)
  );

  drvctl_bias #(.BIAS_W(BIAS_W), .INC_W(INC_W)) u_bias (
    .clk(clk), .rst_n(rst_n), .inc_we(dec.inc), .delta(bus_wdata[INC_W-1:0]),
    .hi_we(dec.bias_hi && ord_accept), .hi_data(bus_wdata[BIAS_W-2:0]),
    .bias_q(bias_ctrl), .last_delta_q(last_delta)
  );

  drvctl_fields #(.DATA_W(DATA_W), .PW_W(PW_W), .DE_W(DE_W), .EQ_W(EQ_W),
                  .EQ_LSB(EQ_LSB)) u_fields (
    .clk(clk), .rst_n(rst_n),
    .pw_we(dec.pw && ord_accept), .de_we(dec.deemph && ord_accept),
    .eq_we(dec.eq && ord_accept), .wdata(bus_wdata),
    .pw_q(pw_ctrl), .de_q(deemph_ctrl), .eq_q(eq_ctrl)
  );

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_BIAS_HI:  rd_next = bias_ctrl[BIAS_W-1:1];
      A_BIAS_INC: begin
        rd_next[INC_W-1:0] = last_delta;
        rd_next[LSB_RD_POS] = bias_ctrl[0];
      end
      A_MODE:     rd_next = mode_q;
      A_PW:       rd_next[PW_W-1:0] = pw_ctrl;
      A_DEEMPH:   rd_next[DE_W-1:0] = deemph_ctrl;
      A_EQ:       rd_next[EQ_LSB +: EQ_W] = eq_ctrl;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_next;
  end

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  p_inc_no_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_BIAS_INC) |=> $stable(mode_q));
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ord_we && !dec.mode && !dec.inc) |=> ($stable(mode_q) && $stable(wr_err)));
endmodule

// File: tb/test_drvctl_regfile.sv
module test_drvctl_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] pw_ctrl;
  logic [5:0] deemph_ctrl;
  logic [1:0] eq_ctrl;
  logic [8:0] bias_ctrl;
  logic wr_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  drvctl_regfile i_drvctl_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pw_ctrl(pw_ctrl), .deemph_ctrl(deemph_ctrl), .eq_ctrl(eq_ctrl),
    .bias_ctrl(bias_ctrl), .wr_err(wr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 pw", pw_ctrl, 0);
    check("R1 deemph", deemph_ctrl, 1);
    check("R1 eq", eq_ctrl, 0);
    check("R1 bias", bias_ctrl, 0);
    check("R1 err", wr_err, 0);
    rd(8'h0E, r); check("R1 mode", r, 8'h00);
    rd(8'h10, r); check("R1 deemph read", r, 8'h01);
  endtask

  task automatic t_unlock();
    logic [7:0] r;
    wr(8'h0F, 8'h05);
    check("R4 locked write dropped", pw_ctrl, 0);
    check("R4 err set", wr_err, 1);
    wr(8'h0E, 8'h12);
    rd(8'h0E, r); check("R2 mode readback", r, 8'h12);
    wr(8'h0F, 8'hA5);
    check("R3 accepted pw", pw_ctrl, 5);
    rd(8'h0F, r); check("R9 pw read, unused zero", r, 8'h05);
    rd(8'h0E, r); check("R3 relocked", r, 8'h00);
    wr(8'h0F, 8'h07);
    check("R3 second write dropped", pw_ctrl, 5);
    check("R4 err sticky", wr_err, 1);
    wr(8'h0E, 8'h13);
    wr(8'h0F, 8'h09);
    check("R2 wrong code keeps lock", pw_ctrl, 5);
    wr(8'h0E, 8'h12);
    rd(8'h0F, r);
    rd(8'h0E, r); check("R10 read keeps unlock", r, 8'h12);
    wr(8'h10, 8'hFF);
    check("R10 unlock survived reads", deemph_ctrl, 6'h3F);
    rd(8'h10, r); check("R9 deemph read", r, 8'h3F);
    wr(8'h0E, 8'h12);
    wr(8'h11, 8'hFF);
    check("R9 eq from bits 2:1", eq_ctrl, 3);
    rd(8'h11, r); check("R9 eq read", r, 8'h06);
    repeat (3) @(negedge clk);
    check("R10 rdata held", bus_rdata, 8'h06);
  endtask

  task automatic t_bias();
    logic [7:0] r;
    wr(8'h0D, 8'h07);
    check("R5 inc while locked", bias_ctrl, 7);
    rd(8'h0D, r); check("R7 inc read", r, 8'h87);
    wr(8'h0E, 8'h12);
    wr(8'h0D, 8'h01);
    check("R6 add", bias_ctrl, 8);
    rd(8'h0E, r); check("R5 inc keeps mode", r, 8'h12);
    wr(8'h0F, 8'h03);
    check("R5 unlock still usable", pw_ctrl, 3);
    wr(8'h0D, 8'h10);
    check("R6 clamp at 0", bias_ctrl, 0);
    wr(8'h0E, 8'h12);
    wr(8'h0C, 8'hFF);
    check("R8 upper load", bias_ctrl, 9'h1FE);
    wr(8'h0D, 8'h01);
    check("R6 reach max", bias_ctrl, 9'h1FF);
    rd(8'h0D, r); check("R7 lsb in bit7", r, 8'h81);
    wr(8'h0D, 8'h0F);
    check("R6 clamp at 511", bias_ctrl, 9'h1FF);
    rd(8'h0C, r); check("R8 upper read", r, 8'hFF);
    wr(8'h0D, 8'h1E);
    check("R6 negative delta", bias_ctrl, 9'h1FD);
    wr(8'h0E, 8'h12);
    wr(8'h0C, 8'h10);
    check("R8 lsb kept", bias_ctrl, 9'h021);
    wr(8'h0D, 8'h80);
    check("R7 bit7 write no effect", bias_ctrl, 9'h021);
    rd(8'h0D, r); check("R7 read after zero delta", r, 8'h80);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    wr(8'h0E, 8'h12);
    wr(8'h20, 8'hFF);
    rd(8'h0E, r); check("R11 unlock not consumed", r, 8'h12);
    rd(8'h20, r); check("R11 unmapped reads zero", r, 8'h00);
    check("R11 pw untouched", pw_ctrl, 3);
  endtask

  task automatic t_err_unmapped();
    logic [7:0] r;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(8'h33, 8'hAA);
    check("R11 no err on unmapped", wr_err, 0);
    rd(8'h0E, r); check("R11 mode unchanged", r, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_bias();
    t_unmapped();
    t_err_unmapped();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule